// File: doc/BRIEF.md
# CAN Node Fault Confinement Tracker

This block holds the two error counters of a CAN node, one for transmit faults and one for receive faults, and classifies the node from them. A node is in one of three modes: fully participating, restricted, or cut off from the bus. An external frame engine decides which bus events count as errors or successes. It reports each one to this block as a single-cycle strobe. The block moves the counters up or down in response and derives the mode.

The outputs are both counters, the mode code and a warning level. They also include a participation enable for the frame engine and the polarity that any error frame must use. The block leaves the cut-off mode by itself, with no host action. It does so once it has watched enough idle bus time. That means 128 runs of 11 recessive samples, taken on a sample strobe from the bit timing logic.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters are zero, the mode code is 2'b00, warning is low, enable is high and the error-frame polarity output is high.
- R2: Outside cut-off, a transmit error strobe adds 8 to the 9-bit transmit counter, saturating at 511. A transmit success strobe subtracts 1, stopping at 0. When both strobes arrive in one cycle, the error strobe wins.
- R3: Outside cut-off, a receive error strobe adds 1 to the 8-bit receive counter, saturating at 255. A receive success strobe subtracts 1, stopping at 0. When both strobes arrive in one cycle, the error strobe wins.
- R4: The mode code is 2'b00 while both counters are below 128. It is 2'b01 while either counter is at or above 128 and the transmit counter is below 256.
- R5: The mode code is 2'b10 whenever the transmit counter is 256 or more. Enable is low in that mode and high in the other two.
- R6: In cut-off mode all four counter event strobes are ignored, and both counters hold their values.
- R7: In cut-off mode a sample strobe with the bus bit at 1 (recessive) extends the current run. The 11th consecutive one completes a run. A sample with the bus bit at 0 (dominant) restarts the current run but keeps the runs already completed. In the cycle that completes the 128th run, both counters clear, and the mode code reads 2'b00 after that clock edge.
- R8: Warning is high while either counter is at or above 96, and low only when both are below 96.
- R9: The error-frame polarity output is high (dominant) only in mode 2'b00. It is low (recessive) in modes 2'b01 and 2'b10.
- R10: Sample strobes taken outside cut-off mode leave no recovery progress. Every entry into cut-off needs the full 128 × 11 recessive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error event strobe |
| rx_err_i | input | 1 | Receive error event strobe |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| sample_i | input | 1 | Bus sample point strobe |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Mode code: 00 active, 01 passive, 10 cut-off |
| warn_o | output | 1 | Warning level |
| enable_o | output | 1 | Node may transmit and receive |
| err_dominant_o | output | 1 | Error frames use dominant bits |

## Verification
On every cycle the assertions check the single-step counter moves, the holding of both counters in cut-off, the bounds that go with the restricted mode, and the blocking of participation and dominant error frames outside the right modes. They also check that the recovery pulse clears both counters. Only the bench's scenarios can show the mode boundaries at exactly 96, 128 and 256 under long mixed event streams. They alone show that a dominant sample restarts just the current run. They also show that the idle time needed to recover counts from zero on every entry into cut-off, and that error strobes win over success strobes.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  localparam int unsigned WARN_LIM    = 96;
  localparam int unsigned PASSIVE_LIM = 128;
  localparam int unsigned BUSOFF_LIM  = 256;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  // Next counter value: error step has priority, success step floors at 0.
  function automatic int unsigned fc_step_count(int unsigned cur, logic up, logic down,
                                                int unsigned step, int unsigned ceiling);
    int unsigned res;
    res = cur;
    if (up) begin
      res = (cur + step > ceiling) ? ceiling : cur + step;
    end else if (down) begin
      res = (cur == 0) ? 0 : cur - 1;
    end
    return res;
  endfunction

  // Mode from the two counter values.
  function automatic fc_state_e fc_classify(int unsigned tec, int unsigned rec);
    if (tec >= BUSOFF_LIM)                         return FC_BUSOFF;
    if (tec >= PASSIVE_LIM || rec >= PASSIVE_LIM)  return FC_PASSIVE;
    return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
  parameter int unsigned W    = 9,
  parameter int unsigned STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  import can_fc_pkg::*;

  localparam int unsigned CEIL = (1 << W) - 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (!hold_i) begin
      cnt_q <= W'(fc_step_count(32'(cnt_q), inc_i, dec_i, STEP, CEIL));
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fc_idle_recovery.sv
module fc_idle_recovery #(
  parameter int unsigned RUN_BITS  = 11,
  parameter int unsigned RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sample_i,
  input  logic bus_bit_i,
  output logic recover_o
);
  localparam int unsigned BIT_W = $clog2(RUN_BITS);
  localparam int unsigned RUN_W = $clog2(RUN_COUNT);

  logic [BIT_W-1:0] bit_q;
  logic [RUN_W-1:0] run_q;
  logic             run_end_w;

  assign run_end_w = sample_i && bus_bit_i && (bit_q == BIT_W'(RUN_BITS - 1));
  assign recover_o = arm_i && run_end_w && (run_q == RUN_W'(RUN_COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (!arm_i || recover_o) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (sample_i) begin
      if (!bus_bit_i) begin
        bit_q <= '0;
      end else if (run_end_w) begin
        bit_q <= '0;
        run_q <= run_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_state_decode.sv
module fc_state_decode #(
  parameter int unsigned TEC_W = 9,
  parameter int unsigned REC_W = 8
) (
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  output logic [1:0]       state_o,
  output logic             busoff_o,
  output logic             warn_o,
  output logic             enable_o,
  output logic             dominant_o
);
  import can_fc_pkg::*;

  fc_state_e st;

  always_comb begin
    st         = fc_classify(32'(tec_i), 32'(rec_i));
    state_o    = st;
    busoff_o   = (st == FC_BUSOFF);
    enable_o   = (st != FC_BUSOFF);
    dominant_o = (st == FC_ACTIVE);
    warn_o     = (32'(tec_i) >= WARN_LIM) || (32'(rec_i) >= WARN_LIM);
  end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned REC_W     = 8,
  parameter int unsigned TEC_STEP  = 8,
  parameter int unsigned REC_STEP  = 1,
  parameter int unsigned RUN_BITS  = 11,
  parameter int unsigned RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             sample_i,
  input  logic             bus_bit_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             warn_o,
  output logic             enable_o,
  output logic             err_dominant_o
);
  logic busoff_w;
  logic recover_w;

  fc_err_counter #(.W(TEC_W), .STEP(TEC_STEP)) u_tec (
    .clk(clk), .rst_n(rst_n), .hold_i(busoff_w), .clr_i(recover_w),
    .inc_i(tx_err_i), .dec_i(tx_ok_i), .cnt_o(tec_o)
  );

  fc_err_counter #(.W(REC_W), .STEP(REC_STEP)) u_rec (
    .clk(clk), .rst_n(rst_n), .hold_i(busoff_w), .clr_i(recover_w),
    .inc_i(rx_err_i), .dec_i(rx_ok_i), .cnt_o(rec_o)
  );

  fc_idle_recovery #(.RUN_BITS(RUN_BITS), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .arm_i(busoff_w), .sample_i(sample_i),
    .bus_bit_i(bus_bit_i), .recover_o(recover_w)
  );

  fc_state_decode #(.TEC_W(TEC_W), .REC_W(REC_W)) u_dec (
    .tec_i(tec_o), .rec_i(rec_o), .state_o(state_o), .busoff_o(busoff_w),
    .warn_o(warn_o), .enable_o(enable_o), .dominant_o(err_dominant_o)
  );
endmodule

// File: rtl/fc_confine_chk.sv
module fc_confine_chk #(
  parameter int unsigned TEC_W    = 9,
  parameter int unsigned REC_W    = 8,
  parameter int unsigned TEC_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err_i,
  input logic             rx_err_i,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic             enable_o,
  input logic             err_dominant_o,
  input logic             busoff_w,
  input logic             recover_w
);
  localparam int unsigned TEC_CEIL = (1 << TEC_W) - 1;
  localparam int unsigned REC_CEIL = (1 << REC_W) - 1;

  // R2
  tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_i && !busoff_w && (32'(tec_o) + TEC_STEP <= TEC_CEIL))
      |=> (32'(tec_o) == 32'($past(tec_o)) + TEC_STEP));

  // R3
  rec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_i && !busoff_w && (32'(rec_o) < REC_CEIL))
      |=> (32'(rec_o) == 32'($past(rec_o)) + 1));

  // R4
  passive_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01) |-> ((tec_o >= 9'd128 || rec_o >= 8'd128) && tec_o < 9'd256));

  // R5
  busoff_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10) |-> !enable_o);

  // R6
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_w && !recover_w) |=> ($stable(tec_o) && $stable(rec_o)));

  // R7
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover_w |=> (tec_o == '0 && rec_o == '0 && state_o == 2'b00));

  // R9
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_dominant_o |-> (state_o == 2'b00));
endmodule

bind can_fault_confine fc_confine_chk #(.TEC_W(TEC_W), .REC_W(REC_W), .TEC_STEP(TEC_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
  .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o), .enable_o(enable_o),
  .err_dominant_o(err_dominant_o), .busoff_w(busoff_w), .recover_w(recover_w)
);

// File: tb/can_fault_confine_bench.sv
module can_fault_confine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err, rx_err, tx_ok, rx_ok, smp, bb;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] st;
  logic warn, en, dom;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench reference state
  int m_tec = 0, m_rec = 0, m_bit = 0, m_run = 0;

  always #2.5 clk = ~clk;

  can_fault_confine u_can_fault_confine (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
    .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .sample_i(smp), .bus_bit_i(bb),
    .tec_o(tec), .rec_o(rec), .state_o(st), .warn_o(warn),
    .enable_o(en), .err_dominant_o(dom)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_state();
    if (m_tec > 255) return 2;
    if (m_tec > 127 || m_rec > 127) return 1;
    return 0;
  endfunction

  task automatic compare_all();
    int es = exp_state();
    chk(es == 2 ? "R6 tec" : "R2 tec", int'(tec), m_tec);
    chk(es == 2 ? "R6 rec" : "R3 rec", int'(rec), m_rec);
    chk(es == 2 ? "R5 state" : "R4 state", int'(st), es);
    chk("R8 warn", int'(warn), (m_tec > 95 || m_rec > 95) ? 1 : 0);
    chk("R5 enable", int'(en), es != 2 ? 1 : 0);
    chk("R9 polarity", int'(dom), es == 0 ? 1 : 0);
  endtask

  task automatic step(bit te, bit re, bit to, bit ro, bit s, bit b);
    bit off;
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; smp = s; bb = b;
    off = (m_tec > 255);
    if (off && s && b && m_bit == 10 && m_run == 127) begin
      m_tec = 0; m_rec = 0; m_bit = 0; m_run = 0;
    end else if (off) begin
      if (s) begin
        if (!b) m_bit = 0;
        else if (m_bit == 10) begin m_bit = 0; m_run = m_run + 1; end
        else m_bit = m_bit + 1;
      end
    end else begin
      m_bit = 0; m_run = 0;
      if (te) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
      else if (to && m_tec > 0) m_tec = m_tec - 1;
      if (re) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
      else if (ro && m_rec > 0) m_rec = m_rec - 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; smp = 0; bb = 1;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tec", int'(tec), 0);
    chk("R1 rec", int'(rec), 0);
    chk("R1 state", int'(st), 0);
    chk("R1 warn", int'(warn), 0);
    chk("R1 enable", int'(en), 1);
    chk("R1 polarity", int'(dom), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Mixed sweep: four phases with differing event weights.
    for (int c = 0; c < 48000; c++) begin
      int ph = (c / 3000) % 4;
      bit te, re, to, ro;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (ph)
        0: begin te = (lf[2:0] == 0); re = lf[3];              to = lf[4];          ro = (lf[6:5] == 0); end
        1: begin te = (lf[3:0] == 0); re = (lf[2:0] == 0);     to = lf[4];          ro = lf[5];          end
        2: begin te = (lf[1:0] == 0); re = lf[6] & lf[7];      to = lf[4];          ro = lf[5] & lf[8];  end
        default: begin te = (lf[2:0] == 1); re = (lf[3:1] == 0); to = lf[4] | lf[9]; ro = lf[5];       end
      endcase
      step(te, re, to, ro, lf[11], lf[15:12] != 0);
    end

    // Return to a clean start for directed checks.
    while (m_tec != 0 || m_rec != 0) begin
      if (m_tec > 255) step(0, 0, 0, 0, 1, 1);
      else step(0, 0, 1, 1, 0, 1);
    end

    // R10: recessive samples while active must not count toward recovery.
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 0, 1);
    chk("R5 entered cut-off", int'(st), 2);
    // R2: error strobe wins over success strobe in the same cycle.
    // (already at 256; check priority on receive side, R3, ignored in cut-off: R6)
    step(0, 1, 0, 1, 0, 1);
    chk("R6 rec ignored", int'(rec), 0);
    // R7: a dominant sample restarts only the current run.
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 128 * 11 - 1; i++) step(0, 0, 0, 0, 1, 1);
    chk("R10 still cut-off", int'(st), 2);
    step(0, 0, 0, 0, 1, 1);
    chk("R7 recovered state", int'(st), 0);
    chk("R7 recovered tec", int'(tec), 0);

    // R2 and R3 priority when error and success strobes coincide.
    step(1, 1, 1, 1, 0, 1);
    chk("R2 priority", int'(tec), 8);
    chk("R3 priority", int'(rec), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule